// File: doc/BRIEF.md
# Forced-Resonant ZVS Gate Timing Controller

This block is the cycle-level gate sequencer of a flyback converter. It drives three gate outputs: the primary switch, the synchronous rectifier (SR) and an auxiliary switch. The auxiliary switch builds up negative magnetizing current just before the primary turns on, so the primary turns on close to zero drain voltage. A free-running cycle count starts at 0 on the first clock the primary gate is high. Every event below is placed on that count. The primary turns off on the current comparator. The SR conducts after a blanking gap and stops on the demagnetization-zero flag.

In high-line operation the engine works backwards from the end of the period. The auxiliary pulse starts at S = period − dead − on-time, lasts on-time clocks, and is followed by dead clocks. The primary then turns on at count = period. In low-line operation no pulse is inserted. The primary waits for demagnetization and for the period to elapse, then turns on in the following valley clock. If the schedule cannot place the pulse without overlapping another gate, the pulse is dropped for that cycle and a skip flag is raised.

All timing settings and the line-mode select are captured together on the clock where a new cycle begins. The settings are the period, dead time, pulse on-time, SR blanking and the comparator blanking (minimum on-time). The pulse on-time is expected to follow the bulk voltage from cycle to cycle.

Top module: `zvs_gate_ctrl`

## Requirements
- R1: At most one of `prim_gate_o`, `sr_gate_o`, `aux_gate_o` is high in any clock. While `rst_ni` is low, all three gates and `zvs_skip_o` are low.
- R2: The primary gate is high from count 0. `cs_trip_i` sampled at a count below the latched minimum on-time has no effect. If it is sampled high at count t ≥ minimum, the primary is high for counts 0..t only.
- R3: Whatever the comparator does, the primary gate is high for at most `MAX_ON` clocks (counts 0..MAX_ON−1).
- R4: After the primary's last high count t, the SR gate rises at count t+1+blank. A blank setting of 0 gives count t+1.
- R5: The SR gate stays high until `demag_zero_i` is sampled high while the SR is on. It is low from the next count. The flag has no effect during primary or blanking time.
- R6: In high line with valid settings, the auxiliary gate is high for counts S..S+on−1, where S = period − dead − on. The primary turns on again at count = period, after exactly dead low clocks.
- R7: In low line, the auxiliary gate never rises. The next primary turn-on happens at count max(period, f+1), where f is the first count at which the SR is low again.
- R8: In high line, if the SR or primary is still on at count S−1, the pulse is skipped. `zvs_skip_o` is high from count S to the end of the cycle, and the cycle ends as in R7.
- R9: High-line settings with on-time 0 or dead+on ≥ period insert no pulse. They raise `zvs_skip_o` from count 0 of that cycle, and the cycle ends as in R7.
- R10: Settings changed in the middle of a cycle take effect only from the next cycle start. The running cycle keeps its old period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_trip_i | input | 1 | Sense current at or above current command |
| demag_zero_i | input | 1 | Demagnetizing current reached zero |
| high_line_i | input | 1 | 1 = forced-resonant (high line), 0 = valley mode |
| period_i | input | TW | Switching period in clocks |
| zvs_dead_i | input | TW | Dead time between auxiliary pulse end and primary turn-on |
| zvs_on_i | input | TW | Auxiliary pulse width |
| sr_blank_i | input | TW | Gap between primary off and SR on |
| min_on_i | input | TW | Comparator blanking at start of primary on-time |
| prim_gate_o | output | 1 | Primary switch gate |
| sr_gate_o | output | 1 | Synchronous rectifier gate |
| aux_gate_o | output | 1 | Auxiliary ZVS switch gate |
| zvs_skip_o | output | 1 | Pulse dropped in the current cycle |

## Verification
The bench runs one complete switching cycle per setting and measures several quantities from that cycle:
- primary width, SR edges, auxiliary start and width, cycle length and the skip flag;
- gate overlap, counted on every clock.

Stimulus patterns and what each separates:
- Comparator trips before, inside and never within the blanking window. These distinguish the minimum on-time from the maximum on-time forcing.
- Demagnetization arrives before SR turn-on, mid-cycle, exactly at the last slot that still allows the pulse, one clock later, and after the period. These separate valid pulse insertion from skipping and from period stretching.
- Low versus high line on identical settings isolates pulse insertion.
- Zero dead time, a wider pulse and invalid pulse settings probe the backwards placement arithmetic.
- A period change mid-cycle shows that settings apply only at a cycle boundary.

// File: rtl/zvs_pkg.sv
package zvs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRIM,
    PH_BLANK,
    PH_SR,
    PH_WAIT,
    PH_AUX,
    PH_DEAD
  } phase_e;
endpackage

// File: rtl/zvs_param_latch.sv
module zvs_param_latch #(
  parameter int TW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          high_line_i,
  input  logic [TW-1:0] period_i,
  input  logic [TW-1:0] zvs_dead_i,
  input  logic [TW-1:0] zvs_on_i,
  input  logic [TW-1:0] sr_blank_i,
  input  logic [TW-1:0] min_on_i,
  output logic          ok_next_o,
  output logic          high_q_o,
  output logic          aux_ok_q_o,
  output logic [TW-1:0] dead_q_o,
  output logic [TW-1:0] blank_q_o,
  output logic [TW-1:0] min_on_q_o,
  output logic [TW-1:0] aux_pre_q_o,
  output logic [TW-1:0] aux_end_q_o,
  output logic [TW-1:0] last_q_o
);
  logic [TW:0]   need;
  logic          ok_d;
  logic [TW-1:0] aux_pre_d, aux_end_d, last_d;

  // pulse must be non-empty and start at count >= 1
  always_comb begin
    need      = {1'b0, zvs_dead_i} + {1'b0, zvs_on_i};
    ok_d      = (zvs_on_i != '0) && (need < {1'b0, period_i});
    aux_pre_d = period_i - zvs_dead_i - zvs_on_i - TW'(1);
    aux_end_d = period_i - zvs_dead_i - TW'(1);
    last_d    = period_i - TW'(1);
  end

  assign ok_next_o = ok_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      high_q_o    <= 1'b0;
      aux_ok_q_o  <= 1'b0;
      dead_q_o    <= '0;
      blank_q_o   <= '0;
      min_on_q_o  <= '0;
      aux_pre_q_o <= '0;
      aux_end_q_o <= '0;
      last_q_o    <= '0;
    end else if (load_i) begin
      high_q_o    <= high_line_i;
      aux_ok_q_o  <= ok_d;
      dead_q_o    <= zvs_dead_i;
      blank_q_o   <= sr_blank_i;
      min_on_q_o  <= min_on_i;
      aux_pre_q_o <= aux_pre_d;
      aux_end_q_o <= aux_end_d;
      last_q_o    <= last_d;
    end
  end

  AST_HOLD_SETTINGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(last_q_o) && $stable(high_q_o) && $stable(aux_pre_q_o)) // R10
    else $error("settings changed outside cycle start");
endmodule

// File: rtl/zvs_cycle_timer.sv
module zvs_cycle_timer #(
  parameter int TW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  output logic [TW-1:0] cnt_o
);
  localparam logic [TW-1:0] CNT_TOP = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (restart_i)         cnt_o <= '0;
    else if (cnt_o != CNT_TOP)  cnt_o <= cnt_o + TW'(1);
  end
endmodule

// File: rtl/zvs_phase_fsm.sv
module zvs_phase_fsm
  import zvs_pkg::*;
#(
  parameter int TW     = 10,
  parameter int MAX_ON = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_trip_i,
  input  logic          demag_zero_i,
  input  logic          high_line_i,
  input  logic          ok_next_i,
  input  logic [TW-1:0] cnt_i,
  input  logic          high_q_i,
  input  logic          aux_ok_q_i,
  input  logic [TW-1:0] dead_q_i,
  input  logic [TW-1:0] blank_q_i,
  input  logic [TW-1:0] min_on_q_i,
  input  logic [TW-1:0] aux_pre_q_i,
  input  logic [TW-1:0] aux_end_q_i,
  input  logic [TW-1:0] last_q_i,
  output logic          start_o,
  output logic          prim_o,
  output logic          sr_o,
  output logic          aux_o,
  output logic          skip_o
);
  localparam logic [TW-1:0] MAX_LAST = TW'(MAX_ON - 1);

  phase_e        state_q, state_d;
  logic [TW-1:0] ph_q;
  logic          skip_q, aux_go, skip_hit, prim_off;

  assign prim_off = (cnt_i >= MAX_LAST) || (cs_trip_i && (cnt_i >= min_on_q_i));
  assign aux_go   = high_q_i && aux_ok_q_i && !skip_q && (cnt_i == aux_pre_q_i);
  assign skip_hit = high_q_i && aux_ok_q_i && (cnt_i == aux_pre_q_i) && (state_q != PH_WAIT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE:  state_d = PH_PRIM;
      PH_PRIM:  if (prim_off) state_d = (blank_q_i == '0) ? PH_SR : PH_BLANK;
      PH_BLANK: if (ph_q == blank_q_i - TW'(1)) state_d = PH_SR;
      PH_SR:    if (demag_zero_i) state_d = PH_WAIT;
      PH_WAIT: begin
        if (aux_go)                  state_d = PH_AUX;
        else if (cnt_i >= last_q_i)  state_d = PH_PRIM;
      end
      PH_AUX:   if (cnt_i == aux_end_q_i) state_d = (dead_q_i == '0) ? PH_PRIM : PH_DEAD;
      PH_DEAD:  if (cnt_i == last_q_i) state_d = PH_PRIM;
      default:  state_d = PH_IDLE;
    endcase
  end

  assign start_o = (state_d == PH_PRIM) && (state_q != PH_PRIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      ph_q    <= '0;
      skip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= (state_d != state_q) ? '0 : ph_q + TW'(1);
      if (start_o)       skip_q <= high_line_i && !ok_next_i;
      else if (skip_hit) skip_q <= 1'b1;
    end
  end

  assign prim_o = (state_q == PH_PRIM);
  assign sr_o   = (state_q == PH_SR);
  assign aux_o  = (state_q == PH_AUX);
  assign skip_o = skip_q;

  AST_GATE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prim_o, sr_o, aux_o})) // R1
    else $error("gate overlap");
  AST_CS_BLANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_o && (cnt_i < min_on_q_i) && (cnt_i < MAX_LAST) |=> prim_o) // R2
    else $error("primary off inside blanking");
  AST_MAX_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prim_o && (cnt_i == MAX_LAST) |=> !prim_o) // R3
    else $error("primary exceeded max on-time");
  AST_SR_DEMAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_o && demag_zero_i |=> !sr_o) // R5
    else $error("SR held after demag");
  AST_AUX_HIGH_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_o |-> high_q_i && aux_ok_q_i && !skip_q) // R6
    else $error("aux pulse outside valid high-line cycle");
  AST_AUX_TO_PRIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(aux_o) && (dead_q_i == '0) |-> prim_o) // R6
    else $error("primary late after aux with zero dead time");
endmodule

// File: rtl/zvs_gate_ctrl.sv
module zvs_gate_ctrl #(
  parameter int TW     = 10,
  parameter int MAX_ON = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_trip_i,
  input  logic          demag_zero_i,
  input  logic          high_line_i,
  input  logic [TW-1:0] period_i,
  input  logic [TW-1:0] zvs_dead_i,
  input  logic [TW-1:0] zvs_on_i,
  input  logic [TW-1:0] sr_blank_i,
  input  logic [TW-1:0] min_on_i,
  output logic          prim_gate_o,
  output logic          sr_gate_o,
  output logic          aux_gate_o,
  output logic          zvs_skip_o
);
  logic          start, ok_next, high_q, aux_ok_q;
  logic [TW-1:0] cnt, dead_q, blank_q, min_on_q, aux_pre_q, aux_end_q, last_q;

  zvs_param_latch #(.TW(TW)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .high_line_i (high_line_i),
    .period_i    (period_i),
    .zvs_dead_i  (zvs_dead_i),
    .zvs_on_i    (zvs_on_i),
    .sr_blank_i  (sr_blank_i),
    .min_on_i    (min_on_i),
    .ok_next_o   (ok_next),
    .high_q_o    (high_q),
    .aux_ok_q_o  (aux_ok_q),
    .dead_q_o    (dead_q),
    .blank_q_o   (blank_q),
    .min_on_q_o  (min_on_q),
    .aux_pre_q_o (aux_pre_q),
    .aux_end_q_o (aux_end_q),
    .last_q_o    (last_q)
  );

  zvs_cycle_timer #(.TW(TW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (start),
    .cnt_o     (cnt)
  );

  zvs_phase_fsm #(.TW(TW), .MAX_ON(MAX_ON)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_trip_i    (cs_trip_i),
    .demag_zero_i (demag_zero_i),
    .high_line_i  (high_line_i),
    .ok_next_i    (ok_next),
    .cnt_i        (cnt),
    .high_q_i     (high_q),
    .aux_ok_q_i   (aux_ok_q),
    .dead_q_i     (dead_q),
    .blank_q_i    (blank_q),
    .min_on_q_i   (min_on_q),
    .aux_pre_q_i  (aux_pre_q),
    .aux_end_q_i  (aux_end_q),
    .last_q_i     (last_q),
    .start_o      (start),
    .prim_o       (prim_gate_o),
    .sr_o         (sr_gate_o),
    .aux_o        (aux_gate_o),
    .skip_o       (zvs_skip_o)
  );
endmodule

// File: tb/zvs_gate_ctrl_test.sv
module zvs_gate_ctrl_test;
  localparam int TW = 10;
  localparam int MAX_ON = 64;

  typedef struct packed {
    int hi, p, d, n, b, m, trip, dem;
    int eon, esrr, esrf, eauxr, eauxl, elen, eskip;
  } vec_t;

  localparam int NV = 14;
  // hi  p   d   n   b  m trip dem | on srr srf auxr auxl len skip
  localparam vec_t VEC [NV] = '{
    '{1, 100, 4, 10, 2, 5,  20,  50,  21, 23,  51, 86, 10, 100, 0}, // R6 nominal
    '{0, 100, 4, 10, 2, 5,  20,  50,  21, 23,  51, -1,  0, 100, 0}, // R7 low line
    '{0, 100, 4, 10, 2, 5,  20, 120,  21, 23, 121, -1,  0, 122, 0}, // R7 stretched
    '{1, 100, 4, 10, 2, 5,   2,  30,   6,  8,  31, 86, 10, 100, 0}, // R2 blanked trip
    '{1, 100, 4, 10, 2, 5, 200,  70,  64, 66,  71, 86, 10, 100, 0}, // R3 max on
    '{1, 100, 4, 10, 2, 5,  20,  84,  21, 23,  85, 86, 10, 100, 0}, // R8 last slot
    '{1, 100, 4, 10, 2, 5,  20,  85,  21, 23,  86, -1,  0, 100, 1}, // R8 skip
    '{1, 100,50, 50, 2, 5,  20,  50,  21, 23,  51, -1,  0, 100, 1}, // R9 too long
    '{1, 100, 4, 10, 0, 5,  20,  50,  21, 21,  51, 86, 10, 100, 0}, // R4 zero blank
    '{1, 100, 0, 10, 2, 5,  20,  50,  21, 23,  51, 90, 10, 100, 0}, // R6 zero dead
    '{1, 100, 4, 20, 2, 5,  20,  50,  21, 23,  51, 76, 20, 100, 0}, // R6 wide pulse
    '{1, 100, 4, 10, 2, 5,  20, 150,  21, 23, 151, -1,  0, 152, 1}, // R8 late demag
    '{1, 100, 4,  0, 2, 5,  20,  50,  21, 23,  51, -1,  0, 100, 1}, // R9 zero on
    '{1, 100, 4, 10, 2, 5,  20,  10,  21, 23,  24, 86, 10, 100, 0}  // R5 early demag
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_trip = 1'b0, demag = 1'b0, high_line = 1'b1;
  logic [TW-1:0] period = 10'd100, zdead = 10'd4, zon = 10'd10, sblank = 10'd2, minon = 10'd5;
  logic prim, sr, aux, skip;

  int trip_at = 20, dem_at = 50;
  int n_run = 0, n_fail = 0;
  int k = 0, cyc_done = 0, cyc_clk = 0;
  int on_len, sr_r, sr_f, aux_r, aux_l, ovl, skip_last;
  int r_on, r_srr, r_srf, r_auxr, r_auxl, r_len, r_skip, r_ovl;
  bit prev_prim = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  zvs_gate_ctrl #(.TW(TW), .MAX_ON(MAX_ON)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_trip_i(cs_trip), .demag_zero_i(demag),
    .high_line_i(high_line), .period_i(period), .zvs_dead_i(zdead), .zvs_on_i(zon),
    .sr_blank_i(sblank), .min_on_i(minon),
    .prim_gate_o(prim), .sr_gate_o(sr), .aux_gate_o(aux), .zvs_skip_o(skip)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle monitor; count k equals the design's cycle count
  always @(negedge clk) begin
    if (rst_n) begin
      if (prim && !prev_prim) begin
        r_on = on_len; r_srr = sr_r; r_srf = sr_f; r_auxr = aux_r;
        r_auxl = aux_l; r_len = k + 1; r_skip = skip_last; r_ovl = ovl;
        k = 0; on_len = 0; sr_r = -1; sr_f = -1; aux_r = -1; aux_l = 0; ovl = 0;
        cyc_done++;
      end else k++;
      if (prim) on_len++;
      if (sr && sr_r < 0) sr_r = k;
      if (!sr && sr_r >= 0 && sr_f < 0) sr_f = k;
      if (aux && aux_r < 0) aux_r = k;
      if (aux) aux_l++;
      if (int'(prim) + int'(sr) + int'(aux) > 1) ovl++;
      skip_last = int'(skip);
      cs_trip = (k >= trip_at);
      demag = (k >= dem_at);
      prev_prim = prim;
    end
  end

  always @(posedge clk) begin
    cyc_clk++;
    if (cyc_clk > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_clk, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wait_cycles(input int n);
    int tgt;
    tgt = cyc_done + n;
    wait (cyc_done >= tgt);
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset prim", int'(prim), 0);
    chk("R1 reset sr", int'(sr), 0);
    chk("R1 reset aux", int'(aux), 0);
    chk("R1 reset skip", int'(skip), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      high_line = VEC[i].hi[0];
      period = TW'(VEC[i].p); zdead = TW'(VEC[i].d); zon = TW'(VEC[i].n);
      sblank = TW'(VEC[i].b); minon = TW'(VEC[i].m);
      trip_at = VEC[i].trip; dem_at = VEC[i].dem;
      wait_cycles(2);
      chk($sformatf("R2/R3 v%0d primary width", i), r_on, VEC[i].eon);
      chk($sformatf("R4 v%0d SR rise", i), r_srr, VEC[i].esrr);
      chk($sformatf("R5 v%0d SR fall", i), r_srf, VEC[i].esrf);
      chk($sformatf("R6 v%0d aux start", i), r_auxr, VEC[i].eauxr);
      chk($sformatf("R6 v%0d aux width", i), r_auxl, VEC[i].eauxl);
      chk($sformatf("R7 v%0d cycle length", i), r_len, VEC[i].elen);
      chk($sformatf("R8/R9 v%0d skip", i), r_skip, VEC[i].eskip);
      chk($sformatf("R1 v%0d overlap", i), r_ovl, 0);
    end

    // R10: period change mid-cycle applies from the next cycle only
    @(negedge clk);
    high_line = 1'b1; period = 10'd100; zdead = 10'd4; zon = 10'd10;
    sblank = 10'd2; minon = 10'd5; trip_at = 20; dem_at = 50;
    wait_cycles(2);
    repeat (30) @(negedge clk);
    period = 10'd150;
    wait_cycles(1);
    chk("R10 running cycle keeps old period", r_len, 100);
    chk("R10 running cycle aux start", r_auxr, 86);
    wait_cycles(1);
    chk("R10 next cycle new period", r_len, 150);
    chk("R10 next cycle aux start", r_auxr, 136);

    // R9: skip flag visible at count 0 of an invalid cycle
    @(negedge clk);
    zon = 10'd0;
    wait (prev_prim == 1'b0);
    wait (prim == 1'b1);
    @(negedge clk);
    chk("R9 skip at cycle start", int'(skip), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule